// File: doc/BRIEF.md
# Accumulator Addressing-Mode Sequencer

This block is the control core of a small multi-cycle accumulator processor. It fetches an opcode word and then one or two operand words. It then makes the extra memory reads that the selected addressing mode needs. Finally it updates the accumulator or the program counter. Four add forms are supported: the operand word is the value, the operand is an address, the operand points to a pointer, or two operands give a base and the address of an index. Two branch forms are supported: the operand is the target, or the operand is a signed offset.

Instructions and data share one word-addressed memory read port with a fixed one-cycle read latency. Memory words carry no type tag. The same word can serve as an opcode, an address or data, depending only on the step of the sequence in which it is read. Each finished instruction raises a one-cycle completion pulse. A word that is not a known opcode stops the machine, and only reset restarts it.

The memory port carries no handshake and accepts no back-pressure. Each read issued with the enable high must be answered on the read-data pins in the next cycle.

Top module: `accum_core`

## Requirements
- R1: While reset is held, the accumulator is 0, the program counter equals RESET_PC, done and halted are low, and a read is requested at RESET_PC.
- R2: Opcode 41 adds the word that follows the opcode to the accumulator. It makes no data read beyond the operand fetch and advances the program counter by 2.
- R3: Opcode 40 treats the following word A as an address and adds mem[A] (low ADDR_W bits of A) to the accumulator. It advances the program counter by 2.
- R4: Opcode 42 adds mem[mem[A]] to the accumulator, using two data reads. It advances the program counter by 2.
- R5: Opcode 43 reads a base B and then an index address X, and adds mem[B + mem[X]] to the accumulator. The sum wraps modulo 2^ADDR_W. The program counter advances by 3.
- R6: Opcode 70 loads the low ADDR_W bits of its operand into the program counter and leaves the accumulator unchanged.
- R7: Opcode 167 sets the program counter to the address of its offset word plus the offset. The offset is taken as two's complement, so a negative value branches backward. The result wraps modulo 2^ADDR_W, and the accumulator is unchanged.
- R8: Read data is used one cycle after its request. done is a single-cycle pulse. Counted from the opcode request, done rises in cycle 3 for opcodes 41, 70 and 167, cycle 4 for 40, cycle 5 for 42 and cycle 6 for 43. The cycle after done requests the next opcode at the updated program counter.
- R9: Any other opcode value sets halted. After that no further reads are made, done stays low, and the accumulator and program counter hold until reset.
- R10: A word fetched as an opcode may also be read as data. Opcode 40 whose address operand points at its own opcode word adds 40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_rd_en | output | 1 | Read request to the shared memory |
| mem_addr | output | ADDR_W | Word address of the read |
| mem_rdata | input | DATA_W | Read data, valid one cycle after the request |
| acc | output | DATA_W | Accumulator |
| pc | output | ADDR_W | Program counter |
| done | output | 1 | One-cycle pulse at the end of each instruction |
| halted | output | 1 | Set by an undefined opcode, cleared only by reset |

## Verification
The bench builds the block with DATA_W = 16, ADDR_W = 8 and RESET_PC = 8. A 16-bit word holds every opcode value and also a negative branch offset such as 0xFFFD. An 8-bit address lets an indexed sum pass 255 and wrap, and lets a wide branch operand have its upper bits dropped. The non-zero start address places programs away from location 0. This means a branch backward, an operand that points at its own opcode, and data placed below the code are all reachable.

// File: rtl/accum_pkg.sv
package accum_pkg;

  typedef enum logic [2:0] {
    ST_FETCH_OP,
    ST_FETCH_W1,
    ST_FETCH_W2,
    ST_DEREF1,
    ST_DEREF2,
    ST_EXEC,
    ST_HALT
  } seq_state_e;

  typedef enum logic [2:0] {
    K_ADD_IMM,
    K_ADD_DIR,
    K_ADD_IND,
    K_ADD_IDX,
    K_JMP_ABS,
    K_JMP_REL,
    K_BAD
  } op_kind_e;

  localparam int unsigned OPC_ADD_DIR = 40;
  localparam int unsigned OPC_ADD_IMM = 41;
  localparam int unsigned OPC_ADD_IND = 42;
  localparam int unsigned OPC_ADD_IDX = 43;
  localparam int unsigned OPC_JMP_ABS = 70;
  localparam int unsigned OPC_JMP_REL = 167;

  function automatic logic is_add(op_kind_e k);
    return (k == K_ADD_IMM) || (k == K_ADD_DIR) || (k == K_ADD_IND) || (k == K_ADD_IDX);
  endfunction

  function automatic logic is_jump(op_kind_e k);
    return (k == K_JMP_ABS) || (k == K_JMP_REL);
  endfunction

endpackage

// File: rtl/accum_decode.sv
module accum_decode #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0]   word,
  output accum_pkg::op_kind_e kind
);
  import accum_pkg::*;

  always_comb begin
    if      (word == DATA_W'(OPC_ADD_IMM)) kind = K_ADD_IMM;
    else if (word == DATA_W'(OPC_ADD_DIR)) kind = K_ADD_DIR;
    else if (word == DATA_W'(OPC_ADD_IND)) kind = K_ADD_IND;
    else if (word == DATA_W'(OPC_ADD_IDX)) kind = K_ADD_IDX;
    else if (word == DATA_W'(OPC_JMP_ABS)) kind = K_JMP_ABS;
    else if (word == DATA_W'(OPC_JMP_REL)) kind = K_JMP_REL;
    else                                   kind = K_BAD;
  end

endmodule

// File: rtl/accum_agu.sv
module accum_agu #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  accum_pkg::seq_state_e state,
  input  accum_pkg::op_kind_e   kind,
  input  logic [ADDR_W-1:0]     pc_q,
  input  logic [DATA_W-1:0]     base_q,
  input  logic [DATA_W-1:0]     rdata,
  output logic                  rd_en,
  output logic [ADDR_W-1:0]     rd_addr,
  output logic [ADDR_W-1:0]     next_pc
);
  import accum_pkg::*;

  localparam logic [ADDR_W-1:0] STEP1 = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] STEP2 = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] STEP3 = ADDR_W'(3);

  // Read address: sequence position decides how the word is interpreted.
  always_comb begin
    rd_en   = 1'b1;
    rd_addr = pc_q;
    unique case (state)
      ST_FETCH_OP: rd_addr = pc_q;
      ST_FETCH_W1: rd_addr = pc_q + STEP1;
      ST_FETCH_W2: rd_addr = pc_q + STEP2;
      ST_DEREF1:   rd_addr = ADDR_W'(rdata);
      ST_DEREF2:   rd_addr = (kind == K_ADD_IDX) ? ADDR_W'(base_q + rdata) : ADDR_W'(rdata);
      default: begin
        rd_en   = 1'b0;
        rd_addr = pc_q;
      end
    endcase
  end

  // Program counter after the instruction; rdata holds the final word in EXEC.
  always_comb begin
    unique case (kind)
      K_ADD_IMM, K_ADD_DIR, K_ADD_IND: next_pc = pc_q + STEP2;
      K_ADD_IDX:                       next_pc = pc_q + STEP3;
      K_JMP_ABS:                       next_pc = ADDR_W'(rdata);
      K_JMP_REL:                       next_pc = pc_q + STEP1 + ADDR_W'(rdata);
      default:                         next_pc = pc_q;
    endcase
  end

endmodule

// File: rtl/accum_seq.sv
module accum_seq #(
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DATA_W-1:0]     rdata,
  input  accum_pkg::op_kind_e   dec_kind,
  output accum_pkg::seq_state_e state,
  output accum_pkg::op_kind_e   kind_q,
  output logic [DATA_W-1:0]     base_q,
  output logic                  done,
  output logic                  halted
);
  import accum_pkg::*;

  seq_state_e state_d;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_FETCH_OP: state_d = ST_FETCH_W1;
      ST_FETCH_W1: begin
        unique case (dec_kind)
          K_BAD:                           state_d = ST_HALT;
          K_ADD_IDX:                       state_d = ST_FETCH_W2;
          K_ADD_DIR, K_ADD_IND:            state_d = ST_DEREF1;
          default:                         state_d = ST_EXEC;
        endcase
      end
      ST_FETCH_W2: state_d = ST_DEREF1;
      ST_DEREF1:   state_d = (kind_q == K_ADD_DIR) ? ST_EXEC : ST_DEREF2;
      ST_DEREF2:   state_d = ST_EXEC;
      ST_EXEC:     state_d = ST_FETCH_OP;
      default:     state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_FETCH_OP;
      kind_q <= K_ADD_IMM;
      base_q <= '0;
    end else begin
      state <= state_d;
      if (state == ST_FETCH_W1) kind_q <= dec_kind;
      if (state == ST_FETCH_W2) base_q <= rdata;
    end
  end

  assign done   = (state == ST_EXEC);
  assign halted = (state == ST_HALT);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done longer than one cycle"); // R8

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted) else $error("halt left without reset"); // R9

  AST_BAD_OPCODE_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FETCH_W1 && dec_kind == K_BAD) |=> halted) else $error("bad opcode ran"); // R9

  AST_IMM_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FETCH_W1 && dec_kind == K_ADD_IMM) |=> done) else $error("immediate made data read"); // R2

endmodule

// File: rtl/accum_core.sv
module accum_core #(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 8,
  parameter int RESET_PC = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] acc,
  output logic [ADDR_W-1:0] pc,
  output logic              done,
  output logic              halted
);
  import accum_pkg::*;

  localparam logic [ADDR_W-1:0] PC_INIT = ADDR_W'(RESET_PC);

  seq_state_e        state;
  op_kind_e          dec_kind;
  op_kind_e          kind_q;
  logic [DATA_W-1:0] base_q;
  logic [DATA_W-1:0] acc_q;
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] next_pc;

  accum_decode #(.DATA_W(DATA_W)) u_dec (
    .word (mem_rdata),
    .kind (dec_kind)
  );

  accum_seq #(.DATA_W(DATA_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .rdata    (mem_rdata),
    .dec_kind (dec_kind),
    .state    (state),
    .kind_q   (kind_q),
    .base_q   (base_q),
    .done     (done),
    .halted   (halted)
  );

  accum_agu #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_agu (
    .state   (state),
    .kind    (kind_q),
    .pc_q    (pc_q),
    .base_q  (base_q),
    .rdata   (mem_rdata),
    .rd_en   (mem_rd_en),
    .rd_addr (mem_addr),
    .next_pc (next_pc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      pc_q  <= PC_INIT;
    end else if (state == ST_EXEC) begin
      pc_q <= next_pc;
      if (is_add(kind_q)) acc_q <= acc_q + mem_rdata;
    end
  end

  assign acc = acc_q;
  assign pc  = pc_q;

  AST_ACC_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(acc_q) |-> $past(done)) else $error("acc moved mid-instruction"); // R2

  AST_PC_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pc_q) |-> $past(done)) else $error("pc moved mid-instruction"); // R7

  AST_JUMP_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    (done && is_jump(kind_q)) |=> $stable(acc_q)) else $error("branch touched acc"); // R6

  AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_rd_en && !done)) else $error("halted core active"); // R9

  AST_FETCH_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (mem_rd_en && mem_addr == pc_q)) else $error("next fetch misplaced"); // R8

endmodule

// File: tb/accum_core_tb.sv
`timescale 1ns/1ps
module accum_core_tb;

  localparam int DW = 16;
  localparam int AW = 8;
  localparam int P  = 8;

  typedef struct packed {
    logic [15:0] op;
    logic [15:0] w1;
    logic [15:0] w2;
    logic [7:0]  a1;
    logic [15:0] v1;
    logic [7:0]  a2;
    logic [15:0] v2;
    logic [15:0] exp_acc;
    logic [7:0]  exp_pc;
    logic [7:0]  exp_n;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{16'd41,  16'd5,      16'd0,  8'd0,  16'd0,  8'd0,  16'd0,  16'd5,      8'd10, 8'd2}, // R2
    '{16'd40,  16'd24,     16'd0,  8'd24, 16'd7,  8'd0,  16'd0,  16'd7,      8'd10, 8'd3}, // R3
    '{16'd42,  16'd36,     16'd0,  8'd36, 16'd24, 8'd24, 16'd11, 16'd11,     8'd10, 8'd4}, // R4
    '{16'd43,  16'd20,     16'd36, 8'd36, 16'd4,  8'd24, 16'd9,  16'd9,      8'd11, 8'd5}, // R5
    '{16'd43,  16'd250,    16'd40, 8'd40, 16'd10, 8'd4,  16'd3,  16'd3,      8'd11, 8'd5}, // R5 wrap
    '{16'd70,  16'd30,     16'd0,  8'd0,  16'd0,  8'd0,  16'd0,  16'd0,      8'd30, 8'd2}, // R6
    '{16'd70,  16'h1234,   16'd0,  8'd0,  16'd0,  8'd0,  16'd0,  16'd0,      8'h34, 8'd2}, // R6 truncation
    '{16'd167, 16'd9,      16'd0,  8'd0,  16'd0,  8'd0,  16'd0,  16'd0,      8'd18, 8'd2}, // R7 forward
    '{16'd167, 16'hFFFD,   16'd0,  8'd0,  16'd0,  8'd0,  16'd0,  16'd0,      8'd6,  8'd2}  // R7 backward
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mem_rd_en;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata = '0;
  logic [DW-1:0] acc;
  logic [AW-1:0] pc;
  logic          done;
  logic          halted;
  logic [DW-1:0] mem [256];

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  always_ff @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= mem[mem_addr];
  end

  accum_core #(.DATA_W(DW), .ADDR_W(AW), .RESET_PC(P)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_rd_en (mem_rd_en),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .acc       (acc),
    .pc        (pc),
    .done      (done),
    .halted    (halted)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = '0;
  endtask

  task automatic hold_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (n < 40) begin
      @(negedge clk);
      n++;
      if (done) break;
    end
  endtask

  function automatic string req_of(input logic [15:0] op);
    case (op)
      16'd41:  return "R2";
      16'd40:  return "R3";
      16'd42:  return "R4";
      16'd43:  return "R5";
      16'd70:  return "R6";
      default: return "R7";
    endcase
  endfunction

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    // R1 reset state
    clear_mem();
    hold_reset();
    chk(acc == 0 && pc == AW'(P), "R1 acc/pc", int'(pc), P);
    chk(!done && !halted, "R1 flags", int'({done, halted}), 0);
    chk(mem_rd_en && mem_addr == AW'(P), "R1 first read", int'(mem_addr), P);

    // Table walk: one instruction per vector
    for (int v = 0; v < NV; v++) begin
      hold_reset();
      clear_mem();
      mem[P]     = VECS[v].op;
      mem[P + 1] = VECS[v].w1;
      mem[P + 2] = VECS[v].w2;
      if (VECS[v].a1 != 0) mem[VECS[v].a1] = VECS[v].v1;
      if (VECS[v].a2 != 0) mem[VECS[v].a2] = VECS[v].v2;
      rst_n = 1'b1;
      wait_done(n);
      chk(n == int'(VECS[v].exp_n), {"R8 latency ", req_of(VECS[v].op)}, n, int'(VECS[v].exp_n));
      @(negedge clk);
      chk(acc == VECS[v].exp_acc, {req_of(VECS[v].op), " acc"}, int'(acc), int'(VECS[v].exp_acc));
      chk(pc == VECS[v].exp_pc, {req_of(VECS[v].op), " pc"}, int'(pc), int'(VECS[v].exp_pc));
      chk(!done && mem_rd_en && mem_addr == VECS[v].exp_pc, "R8 pulse/next fetch", int'(mem_addr), int'(VECS[v].exp_pc));
    end

    // R10: operand points at its own opcode word
    hold_reset();
    clear_mem();
    mem[P]     = 16'd40;
    mem[P + 1] = 16'(P);
    rst_n = 1'b1;
    wait_done(n);
    @(negedge clk);
    chk(acc == 16'd40, "R10 opcode read as data", int'(acc), 40);

    // Program run: two adds accumulate, then an undefined opcode halts (R9)
    hold_reset();
    clear_mem();
    mem[8]  = 16'd41; mem[9]  = 16'd5;
    mem[10] = 16'd40; mem[11] = 16'd30;
    mem[30] = 16'd100;
    mem[12] = 16'd99;
    rst_n = 1'b1;
    begin
      int pulses = 0;
      int waited = 0;
      while (!halted && waited < 40) begin
        @(negedge clk);
        waited++;
        if (done) pulses++;
      end
      chk(pulses == 2, "R8 done pulse count", pulses, 2);
    end
    chk(halted == 1'b1, "R9 halted set", int'(halted), 1);
    chk(acc == 16'd105, "R9 acc held after accumulate", int'(acc), 105);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(!mem_rd_en && !done && pc == 8'd12 && acc == 16'd105, "R9 silent while halted",
          int'(mem_rd_en), 0);
    end

    // R1: reset leaves the halt state
    hold_reset();
    chk(!halted && pc == AW'(P), "R1 reset clears halt", int'(halted), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule